// File: doc/BRIEF.md
# Extended Accumulator Register Unit

This block holds one 36-bit accumulator built from three parts: a 4-bit guard (extension) field in bits 35..32, a 16-bit high word in bits 31..16 and a 16-bit low word in bits 15..0. Each clock it either accumulates a 36-bit operand into the register, takes a write of one of five kinds, or holds its value.

There are five write kinds. A full write takes a complete 36-bit result. A word write puts a 16-bit value in the high word, clears the low word and fills the guard bits with the sign. Three part writes each change exactly one of the guard field, the high word or the low word. A full write copies an accumulator unchanged. A word write moves an accumulator as a signed word.

The unit keeps two status outputs. One reports that the guard bits carry significant data. The other reports that an add or subtract overflowed the full 36-bit range. The second flag is sticky until a clear input is asserted.

Top module: `ext_acc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_q` becomes 0 and `ext_used` and `ovf` become 0.
- R2: With `acc_op` idle and `wr_mode` = 1 (full), `acc_q` takes all 36 bits of `din_full` unchanged.
- R3: With `acc_op` idle and `wr_mode` = 2 (word), `acc_q[31:16]` takes `din_word`, `acc_q[15:0]` becomes 0, and each of `acc_q[35:32]` becomes a copy of `din_word[15]`.
- R4: With `acc_op` idle, `wr_mode` = 4 writes `din_word` into `acc_q[31:16]` and `wr_mode` = 5 writes it into `acc_q[15:0]`. The other bits are unchanged and no sign extension is applied.
- R5: With `acc_op` idle and `wr_mode` = 3 (guard), `acc_q[35:32]` takes `din_word[3:0]` and bits 31..0 are unchanged.
- R6: `acc_op` = 1 replaces `acc_q` with `acc_q + din_full`, and `acc_op` = 2 replaces it with `acc_q - din_full`, both modulo 2^36. An active `acc_op` takes priority over `wr_mode`. `acc_op` values 0 and 3 are idle.
- R7: `ext_used` is 1 exactly when bits 35..31 of `acc_q` are not all equal. It updates on the same edge as `acc_q`.
- R8: `ovf` is set when an add or subtract overflows as a signed 36-bit operation. Once set, it stays set through later writes and accumulations.
- R9: `v_clr` clears `ovf` on the next edge, unless an overflowing accumulation happens on that same edge; in that case `ovf` stays set.
- R10: With `acc_op` idle and `wr_mode` = 0 or 6..7, `acc_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 3 | Write kind: 0 none, 1 full, 2 word, 3 guard, 4 high, 5 low |
| acc_op | input | 2 | Accumulate: 0 idle, 1 add, 2 subtract, 3 idle |
| din_full | input | 36 | Full-width write data or accumulate operand |
| din_word | input | 16 | Word, high, low or guard write data |
| v_clr | input | 1 | Clears the sticky overflow flag |
| acc_q | output | 36 | Accumulator value |
| ext_used | output | 1 | Guard bits hold significant data |
| ovf | output | 1 | Sticky 36-bit signed overflow |

## Verification
Every result is registered. The accumulator value, the guard-in-use flag and the overflow flag all follow a stimulus by exactly one rising edge. The bench drives inputs on the falling edge and samples all three outputs on the next falling edge, half a cycle after the updating edge. A vector table chains writes and accumulations, so each expected value depends on the one before. Directed steps then cover sticky overflow, clear-versus-set priority and accumulate-versus-write priority, each checked on the first sample after its edge.

// File: rtl/ext_acc_pkg.sv
package ext_acc_pkg;
  localparam int EXT_W  = 4;
  localparam int PART_W = 16;
  localparam int ACC_W  = EXT_W + 2 * PART_W;

  typedef enum logic [2:0] {
    WM_NONE = 3'd0,
    WM_FULL = 3'd1,
    WM_WORD = 3'd2,
    WM_EXT  = 3'd3,
    WM_HI   = 3'd4,
    WM_LO   = 3'd5
  } wmode_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_RSV  = 2'd3
  } accop_t;
endpackage

// File: rtl/ext_acc_wrmux.sv
module ext_acc_wrmux #(
  parameter int EXT_W  = 4,
  parameter int PART_W = 16,
  localparam int ACC_W = EXT_W + 2 * PART_W
) (
  input  logic [2:0]        mode,
  input  logic [ACC_W-1:0]  cur,
  input  logic [ACC_W-1:0]  din_full,
  input  logic [PART_W-1:0] din_word,
  output logic              wr_en,
  output logic [ACC_W-1:0]  wr_val
);
  import ext_acc_pkg::*;

  localparam int LO_MSB = PART_W - 1;
  localparam int HI_LSB = PART_W;
  localparam int HI_MSB = 2 * PART_W - 1;
  localparam int EX_LSB = 2 * PART_W;

  wmode_t m;
  assign m = wmode_t'(mode);

  always_comb begin
    wr_en  = 1'b1;
    wr_val = cur;
    case (m)
      WM_FULL: wr_val = din_full;
      WM_WORD: wr_val = {{EXT_W{din_word[PART_W-1]}}, din_word, {PART_W{1'b0}}};
      WM_EXT:  wr_val[ACC_W-1:EX_LSB] = din_word[EXT_W-1:0];
      WM_HI:   wr_val[HI_MSB:HI_LSB]  = din_word;
      WM_LO:   wr_val[LO_MSB:0]       = din_word;
      default: wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_acc_addsub.sv
module ext_acc_addsub #(
  parameter int W = 36
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/ext_acc_guard.sv
module ext_acc_guard #(
  parameter int EXT_W  = 4,
  parameter int PART_W = 16,
  localparam int ACC_W = EXT_W + 2 * PART_W,
  localparam int TOP_W = EXT_W + 1
) (
  input  logic [ACC_W-1:0] val,
  output logic             in_use
);
  logic [TOP_W-1:0] top;

  always_comb begin
    top    = val[ACC_W-1 -: TOP_W];
    in_use = !((top == {TOP_W{1'b0}}) || (top == {TOP_W{1'b1}}));
  end
endmodule

// File: rtl/ext_acc_unit.sv
module ext_acc_unit #(
  parameter int EXT_W  = 4,
  parameter int PART_W = 16,
  localparam int ACC_W = EXT_W + 2 * PART_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        wr_mode,
  input  logic [1:0]        acc_op,
  input  logic [ACC_W-1:0]  din_full,
  input  logic [PART_W-1:0] din_word,
  input  logic              v_clr,
  output logic [ACC_W-1:0]  acc_q,
  output logic              ext_used,
  output logic              ovf
);
  import ext_acc_pkg::*;

  accop_t           op;
  logic             do_acc;
  logic             wr_en;
  logic [ACC_W-1:0] wr_val;
  logic [ACC_W-1:0] sum;
  logic             sum_ovf;
  logic [ACC_W-1:0] nxt;
  logic             nxt_e;

  assign op     = accop_t'(acc_op);
  assign do_acc = (op == OP_ADD) || (op == OP_SUB);

  ext_acc_wrmux #(.EXT_W(EXT_W), .PART_W(PART_W)) u_wr (
    .mode(wr_mode), .cur(acc_q), .din_full(din_full), .din_word(din_word),
    .wr_en(wr_en), .wr_val(wr_val)
  );

  ext_acc_addsub #(.W(ACC_W)) u_alu (
    .a(acc_q), .b(din_full), .sub(op == OP_SUB), .sum(sum), .ovf(sum_ovf)
  );

  always_comb begin
    if (do_acc)     nxt = sum;
    else if (wr_en) nxt = wr_val;
    else            nxt = acc_q;
  end

  ext_acc_guard #(.EXT_W(EXT_W), .PART_W(PART_W)) u_guard (
    .val(nxt), .in_use(nxt_e)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ext_used <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      acc_q    <= nxt;
      ext_used <= nxt_e;
      if (do_acc && sum_ovf) ovf <= 1'b1;
      else if (v_clr)        ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_acc_chk.sv
module ext_acc_chk #(
  parameter int EXT_W  = 4,
  parameter int PART_W = 16,
  localparam int ACC_W = EXT_W + 2 * PART_W
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        wr_mode,
  input logic [1:0]        acc_op,
  input logic [ACC_W-1:0]  din_full,
  input logic [PART_W-1:0] din_word,
  input logic              v_clr,
  input logic [ACC_W-1:0]  acc_q,
  input logic              ext_used,
  input logic              ovf
);
  logic idle;
  assign idle = (acc_op == 2'd0) || (acc_op == 2'd3);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (acc_q == '0 && !ext_used && !ovf));

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_mode == 3'd1) |=> acc_q == $past(din_full));

  // R3
  word_write_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_mode == 3'd2) |=>
      (acc_q[2*PART_W-1:PART_W] == $past(din_word) && acc_q[PART_W-1:0] == '0 &&
       acc_q[ACC_W-1:2*PART_W] == {EXT_W{$past(din_word[PART_W-1])}}));

  // R4
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_mode == 3'd5) |=>
      (acc_q[PART_W-1:0] == $past(din_word) && $stable(acc_q[ACC_W-1:PART_W])));

  // R7
  guard_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ext_used == !(acc_q[ACC_W-1:2*PART_W-1] == '0 || acc_q[ACC_W-1:2*PART_W-1] == '1));

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !v_clr) |=> ovf);

  // R9
  clear_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (v_clr && idle) |=> !ovf);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && (wr_mode == 3'd0 || wr_mode > 3'd5)) |=> $stable(acc_q));
endmodule

bind ext_acc_unit ext_acc_chk #(.EXT_W(EXT_W), .PART_W(PART_W)) u_chk (.*);

// File: tb/tb_ext_acc_unit.sv
module tb_ext_acc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  wr_mode = '0;
  logic [1:0]  acc_op = '0;
  logic [35:0] din_full = '0;
  logic [15:0] din_word = '0;
  logic        v_clr = 1'b0;
  logic [35:0] acc_q;
  logic        ext_used;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_acc_unit dut (.*);

  // {mode, op, full, word, exp_acc, exp_e}
  localparam int NV = 9;
  localparam logic [93:0] VEC [NV] = '{
    {3'd1, 2'd0, 36'h8_1234_5678, 16'h0000, 36'h8_1234_5678, 1'b1},
    {3'd2, 2'd0, 36'h0,           16'h8001, 36'hF_8001_0000, 1'b0},
    {3'd5, 2'd0, 36'h0,           16'hABCD, 36'hF_8001_ABCD, 1'b0},
    {3'd4, 2'd0, 36'h0,           16'h1234, 36'hF_1234_ABCD, 1'b1},
    {3'd3, 2'd0, 36'h0,           16'h0005, 36'h5_1234_ABCD, 1'b1},
    {3'd2, 2'd0, 36'h0,           16'h7FFF, 36'h0_7FFF_0000, 1'b0},
    {3'd0, 2'd1, 36'h0_0001_0000, 16'h0000, 36'h0_8000_0000, 1'b1},
    {3'd0, 2'd2, 36'h0_8000_0001, 16'h0000, 36'hF_FFFF_FFFF, 1'b0},
    {3'd0, 2'd1, 36'h0_0000_0001, 16'h0000, 36'h0_0000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [1:0] op, input logic [35:0] f,
                      input logic [15:0] w, input logic clr);
    @(negedge clk);
    wr_mode = m; acc_op = op; din_full = f; din_word = w; v_clr = clr;
    @(negedge clk);
    wr_mode = '0; acc_op = '0; v_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 acc", acc_q, '0);
    chk("R1 e", {35'b0, ext_used}, 36'd0);
    chk("R1 v", {35'b0, ovf}, 36'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][93:91], VEC[i][90:89], VEC[i][88:53], VEC[i][52:37], 1'b0);
      chk("R2-R6 table acc", acc_q, VEC[i][36:1]);
      chk("R7 table e", {35'b0, ext_used}, {35'b0, VEC[i][0]});
      chk("R8 table v", {35'b0, ovf}, 36'd0);
    end

    // R10: hold with reserved mode and reserved op
    step(3'd7, 2'd3, 36'hF_FFFF_FFFF, 16'hFFFF, 1'b0);
    chk("R10 hold", acc_q, 36'h0);

    // R8: positive overflow of add
    step(3'd1, 2'd0, 36'h7_FFFF_FFFF, 16'h0, 1'b0);
    chk("R7 e", {35'b0, ext_used}, 36'd1);
    step(3'd0, 2'd1, 36'h0_0000_0001, 16'h0, 1'b0);
    chk("R8 add wrap", acc_q, 36'h8_0000_0000);
    chk("R8 v set", {35'b0, ovf}, 36'd1);
    // R8 sticky through a word write
    step(3'd2, 2'd0, 36'h0, 16'h0000, 1'b0);
    chk("R8 sticky v", {35'b0, ovf}, 36'd1);
    chk("R3 zero word", acc_q, 36'h0);
    // R9 clear
    step(3'd0, 2'd0, 36'h0, 16'h0, 1'b1);
    chk("R9 clear", {35'b0, ovf}, 36'd0);

    // R9: set beats clear on subtract overflow
    step(3'd1, 2'd0, 36'h8_0000_0000, 16'h0, 1'b0);
    step(3'd0, 2'd2, 36'h0_0000_0001, 16'h0, 1'b1);
    chk("R6 sub wrap", acc_q, 36'h7_FFFF_FFFF);
    chk("R9 set wins", {35'b0, ovf}, 36'd1);
    step(3'd0, 2'd0, 36'h0, 16'h0, 1'b1);

    // R6: accumulate has priority over a word write
    step(3'd1, 2'd0, 36'h0_0000_0010, 16'h0, 1'b0);
    step(3'd2, 2'd1, 36'h0_0000_0005, 16'h8000, 1'b0);
    chk("R6 priority", acc_q, 36'h0_0000_0015);
    chk("R9 no ovf", {35'b0, ovf}, 36'd0);

    // R4: high write keeps guard and low bits
    step(3'd1, 2'd0, 36'hA_5555_6666, 16'h0, 1'b0);
    step(3'd4, 2'd0, 36'h0, 16'h8888, 1'b0);
    chk("R4 hi only", acc_q, 36'hA_8888_6666);
    // R5: guard write uses low four bits only
    step(3'd3, 2'd0, 36'h0, 16'hFFF3, 1'b0);
    chk("R5 guard", acc_q, 36'h3_8888_6666);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 again", acc_q, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule